// File: doc/BRIEF.md
# Subword Compare-and-Set Unit

This block compares one lane of operand A with one lane of operand B, or with a 16-bit immediate that stands in for B, and reduces the outcome to a Boolean value of 0 or 1. Each side has its own lane width: the full 32-bit word, a halfword or a byte. Each side also has its own signedness, and a part select chooses which halfword or byte is used. Before the compare, both lanes are widened to 33 bits, each according to its own signedness. This keeps every mix of signed and unsigned operands exact.

The Boolean outcome then goes through a second stage together with a third operand C. The second stage can pass the outcome through as is, place it into one halfword or byte lane of C, add it to C, or take the unsigned minimum or maximum with C. There is no saturation, and the intermediate value is always unsigned. One register stage holds the final word. Zero and sign condition flags are also held, and they change only when the issuing operation asks for them.

Top module: `scmp_unit`

## Requirements
- R1: `cmp_sel` picks the test with these codes: 0 never, 1 A<B, 2 A==B, 3 A<=B, 4 A>B, 5 A!=B, 6 A>=B, 7 always. The Boolean outcome is exactly 1 when the test holds and 0 when it does not.
- R2: `a_fmt` and `b_fmt` each pick a format with these codes: 0 signed 32, 1 unsigned 32, 2 signed 16, 3 unsigned 16, 4 signed 8, 5 unsigned 8. Codes 6 and 7 act as 0 and 1. Each lane is widened by its own signedness, so a compare between mixed formats follows true integer order.
- R3: For byte formats the 2-bit part select picks byte 0 to 3, where byte k is bits 8k+7:8k. For halfword formats its bit 0 picks halfword 0 (bits 15:0) or halfword 1 (bits 31:16). The part select has no effect on 32-bit formats.
- R4: When `use_imm` is 1, the 16-bit `imm` replaces operand B and `b_part` is ignored. The immediate is signed 16 when `b_fmt[0]` is 0 and unsigned 16 when it is 1.
- R5: With `op_sel` = 0 (pass), the result is the Boolean outcome zero-extended to 32 bits.
- R6: With `op_sel` set to 1, 2, 3 or 4, the Boolean outcome, zero-extended to the lane width, is written into a lane of C and every other bit of C is kept. The lanes are: 1 bits 31:16, 2 bits 15:0, 3 bits 7:0, 4 bits 23:16.
- R7: With `op_sel` = 5, the result is C plus the Boolean outcome, modulo 2^32.
- R8: With `op_sel` = 6 or 7, the result is the unsigned 32-bit minimum (6) or maximum (7) of the Boolean outcome and C.
- R9: `zero_flag` (result equals 0) and `sign_flag` (result bit 31) take the new result's values only for an accepted operation with `cc_we` = 1. Otherwise they keep their values.
- R10: An operation accepted with `in_valid` shows up on `result` with `out_valid` high on the next clock edge. Without `in_valid`, `out_valid` goes low and `result` holds.
- R11: After reset, `out_valid`, `result`, `zero_flag` and `sign_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| cmp_sel | input | 3 | Compare test code |
| a_fmt | input | 3 | Format of operand A |
| b_fmt | input | 3 | Format of operand B or immediate |
| a_part | input | 2 | Lane select for A |
| b_part | input | 2 | Lane select for B |
| use_imm | input | 1 | Immediate replaces B |
| imm | input | DATA_W/2 | Immediate value |
| op_sel | input | 3 | Second-stage operation |
| cc_we | input | 1 | Update condition flags |
| a_in | input | DATA_W | Operand A |
| b_in | input | DATA_W | Operand B |
| c_in | input | DATA_W | Operand C |
| out_valid | output | 1 | Result valid |
| result | output | DATA_W | Final result |
| zero_flag | output | 1 | Result was zero |
| sign_flag | output | 1 | Result bit 31 |

## Verification
The bound checker examines several properties on every cycle:
- pass results never have bits above bit 0 set;
- the never and always tests give constant outcomes;
- merges leave the untouched half of C intact;
- accumulation rises by at most one over C;
- minimum and maximum bound C correctly;
- the flags follow the result or hold it;
- valid timing and result hold are correct.

Which lane the part select reaches, the exact ordering of mixed signed and unsigned lanes, immediate signedness, and byte-lane merges all depend on data values. The bench's scoreboard shows these through directed corner cases and random operations compared against an independent model.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_code_e;

    typedef enum logic [2:0] {
        POST_PASS   = 3'd0,
        POST_INS_HI = 3'd1,
        POST_INS_LO = 3'd2,
        POST_INS_B0 = 3'd3,
        POST_INS_B2 = 3'd4,
        POST_ADD    = 3'd5,
        POST_MIN    = 3'd6,
        POST_MAX    = 3'd7
    } post_op_e;
endpackage

// File: rtl/scmp_lane_pick.sv
module scmp_lane_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [2:0]         fmt,
    input  logic [1:0]         sel,
    output logic signed [DATA_W:0] ext
);
    localparam int HW = DATA_W / 2;
    localparam int BW = DATA_W / 4;

    logic          is_signed;
    logic [HW-1:0] half_lane;
    logic [BW-1:0] byte_lane;

    always_comb begin
        // even format codes are signed
        is_signed = ~fmt[0];
        half_lane = word[sel[0]*HW +: HW];
        byte_lane = word[sel*BW +: BW];
        unique case (fmt[2:1])
            2'b01:   ext = {{(DATA_W+1-HW){is_signed & half_lane[HW-1]}}, half_lane};
            2'b10:   ext = {{(DATA_W+1-BW){is_signed & byte_lane[BW-1]}}, byte_lane};
            default: ext = {is_signed & word[DATA_W-1], word};
        endcase
    end
endmodule

// File: rtl/scmp_compare.sv
module scmp_compare
    import scmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic signed [DATA_W:0] lhs,
    input  logic signed [DATA_W:0] rhs,
    input  logic [2:0]             code,
    output logic                   hit
);
    logic lt, eq;

    always_comb begin
        lt = lhs < rhs;
        eq = lhs == rhs;
        unique case (cmp_code_e'(code))
            CMP_NEVER:  hit = 1'b0;
            CMP_LT:     hit = lt;
            CMP_EQ:     hit = eq;
            CMP_LE:     hit = lt | eq;
            CMP_GT:     hit = ~(lt | eq);
            CMP_NE:     hit = ~eq;
            CMP_GE:     hit = ~lt;
            default:    hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/scmp_post.sv
module scmp_post
    import scmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        op,
    input  logic              hit,
    input  logic [DATA_W-1:0] c_val,
    output logic [DATA_W-1:0] res
);
    localparam int HW = DATA_W / 2;
    localparam int BW = DATA_W / 4;

    logic [DATA_W-1:0] flag_word;

    always_comb begin
        flag_word = DATA_W'(hit);
        res       = c_val;
        unique case (post_op_e'(op))
            POST_PASS:   res = flag_word;
            POST_INS_HI: res[HW +: HW] = flag_word[HW-1:0];
            POST_INS_LO: res[0 +: HW] = flag_word[HW-1:0];
            POST_INS_B0: res[0 +: BW] = flag_word[BW-1:0];
            POST_INS_B2: res[2*BW +: BW] = flag_word[BW-1:0];
            POST_ADD:    res = c_val + flag_word;
            POST_MIN:    res = (flag_word < c_val) ? flag_word : c_val;
            default:     res = (flag_word > c_val) ? flag_word : c_val;
        endcase
    end
endmodule

// File: rtl/scmp_unit.sv
module scmp_unit #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          cmp_sel,
    input  logic [2:0]          a_fmt,
    input  logic [2:0]          b_fmt,
    input  logic [1:0]          a_part,
    input  logic [1:0]          b_part,
    input  logic                use_imm,
    input  logic [DATA_W/2-1:0] imm,
    input  logic [2:0]          op_sel,
    input  logic                cc_we,
    input  logic [DATA_W-1:0]   a_in,
    input  logic [DATA_W-1:0]   b_in,
    input  logic [DATA_W-1:0]   c_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                zero_flag,
    output logic                sign_flag
);
    localparam int HW = DATA_W / 2;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              zf;
        logic              sf;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]      b_word;
    logic [2:0]             b_fmt_eff;
    logic [1:0]             b_part_eff;
    logic signed [DATA_W:0] a_ext, b_ext;
    logic                   hit;
    logic [DATA_W-1:0]      post_res;

    always_comb begin
        if (use_imm) begin
            b_word     = {{(DATA_W-HW){1'b0}}, imm};
            b_fmt_eff  = {2'b01, b_fmt[0]};
            b_part_eff = 2'b00;
        end else begin
            b_word     = b_in;
            b_fmt_eff  = b_fmt;
            b_part_eff = b_part;
        end
    end

    scmp_lane_pick #(.DATA_W(DATA_W)) i_pick_a (
        .word(a_in), .fmt(a_fmt), .sel(a_part), .ext(a_ext)
    );

    scmp_lane_pick #(.DATA_W(DATA_W)) i_pick_b (
        .word(b_word), .fmt(b_fmt_eff), .sel(b_part_eff), .ext(b_ext)
    );

    scmp_compare #(.DATA_W(DATA_W)) i_cmp (
        .lhs(a_ext), .rhs(b_ext), .code(cmp_sel), .hit(hit)
    );

    scmp_post #(.DATA_W(DATA_W)) i_post (
        .op(op_sel), .hit(hit), .c_val(c_in), .res(post_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = post_res;
            if (cc_we) begin
                st_d.zf = (post_res == '0);
                st_d.sf = post_res[DATA_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign zero_flag = st_q.zf;
    assign sign_flag = st_q.sf;
endmodule

// File: rtl/scmp_unit_chk.sv
module scmp_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        cmp_sel,
    input logic [2:0]        op_sel,
    input logic              cc_we,
    input logic [DATA_W-1:0] c_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag,
    input logic              sign_flag
);
    localparam int HW = DATA_W / 2;

    AST_PASS_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0) |=> (result[DATA_W-1:1] == '0)); // R5
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0 && cmp_sel == 3'd0) |=> (result == '0)); // R1
    AST_ALWAYS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0 && cmp_sel == 3'd7) |=> (result == DATA_W'(1))); // R1
    AST_MERGE_LO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd2) |=> (result[DATA_W-1:HW] == $past(c_in[DATA_W-1:HW]))); // R6
    AST_MERGE_HI_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd1) |=> (result[HW-1:0] == $past(c_in[HW-1:0]))); // R6
    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd5) |=> ((result - $past(c_in)) <= DATA_W'(1))); // R7
    AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd6) |=> (result <= $past(c_in) && result <= DATA_W'(1))); // R8
    AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd7) |=> (result >= $past(c_in))); // R8
    AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cc_we) |=> (zero_flag == (result == '0) && sign_flag == result[DATA_W-1])); // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && cc_we) |=> ($stable(zero_flag) && $stable(sign_flag))); // R9
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R10
endmodule

bind scmp_unit scmp_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_scmp_unit.sv
module test_scmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  cmp_sel = '0, a_fmt = '0, b_fmt = '0, op_sel = '0;
    logic [1:0]  a_part = '0, b_part = '0;
    logic        use_imm = 1'b0, cc_we = 1'b0;
    logic [15:0] imm = '0;
    logic [31:0] a_in = '0, b_in = '0, c_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        zero_flag, sign_flag;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] res;
        logic        zf;
        logic        sf;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic        exp_zf = 1'b0, exp_sf = 1'b0;
    logic [31:0] last_res = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    scmp_unit i_scmp_unit (.*);

    function automatic longint lane_val(logic [31:0] w, int fmt, int sel);
        int          width;
        logic [31:0] v;
        width = (fmt == 2 || fmt == 3) ? 16 : (fmt == 4 || fmt == 5) ? 8 : 32;
        if (width == 8)       v = (w >> (8 * sel)) & 32'hFF;
        else if (width == 16) v = (w >> (16 * (sel % 2))) & 32'hFFFF;
        else                  v = w;
        if ((fmt % 2) == 0 && v[width-1]) return longint'(v) - (longint'(1) << width);
        return longint'(v);
    endfunction

    function automatic logic [31:0] model(int cmp, int af, int bf, int ap, int bp,
                                          bit ui, logic [15:0] iv, int op,
                                          logic [31:0] a, logic [31:0] b, logic [31:0] c);
        longint      x, y;
        bit          h;
        logic [31:0] r;
        x = lane_val(a, af, ap);
        y = ui ? lane_val({16'h0, iv}, (bf % 2) ? 3 : 2, 0) : lane_val(b, bf, bp);
        case (cmp)
            0: h = 0;       1: h = x < y;   2: h = x == y;  3: h = x <= y;
            4: h = x > y;   5: h = x != y;  6: h = x >= y;  default: h = 1;
        endcase
        r = c;
        case (op)
            0: r = {31'h0, h};
            1: r[31:16] = {15'h0, h};
            2: r[15:0] = {15'h0, h};
            3: r[7:0] = {7'h0, h};
            4: r[23:16] = {7'h0, h};
            5: r = c + {31'h0, h};
            6: r = ({31'h0, h} < c) ? {31'h0, h} : c;
            default: r = ({31'h0, h} > c) ? {31'h0, h} : c;
        endcase
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(string tag, int cmp, int af, int bf, int ap, int bp, bit ui,
                         logic [15:0] iv, int op, bit we,
                         logic [31:0] a, logic [31:0] b, logic [31:0] c);
        item_t it;
        cmp_sel = 3'(cmp); a_fmt = 3'(af); b_fmt = 3'(bf);
        a_part = 2'(ap); b_part = 2'(bp); use_imm = ui; imm = iv;
        op_sel = 3'(op); cc_we = we; a_in = a; b_in = b; c_in = c;
        in_valid = 1'b1;
        it.res = model(cmp, af, bf, ap, bp, ui, iv, op, a, b, c);
        if (we) begin
            exp_zf = (it.res == 0);
            exp_sf = it.res[31];
        end
        it.zf = exp_zf; it.sf = exp_sf; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10 unexpected out_valid", 32'h1, 32'h0);
                end else begin
                    item_t e;
                    e = sb_q.pop_front();
                    check(result == e.res, e.tag, result, e.res);
                    check({zero_flag, sign_flag} == {e.zf, e.sf}, {e.tag, " R9 flags"},
                          {30'h0, zero_flag, sign_flag}, {30'h0, e.zf, e.sf});
                end
                last_res = result;
            end else begin
                check(result == last_res, "R10 hold while idle", result, last_res);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0 && result == 0 && zero_flag == 0 && sign_flag == 0,
              "R11 reset state", {result[31:3], out_valid, zero_flag, sign_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: all tests, 5 vs 7 and 7 vs 7
        for (int k = 0; k < 8; k++) issue("R1 test codes 5v7", k, 0, 0, 0, 0, 0, 0, 0, 0, 5, 7, 0);
        for (int k = 0; k < 8; k++) issue("R1 test codes 7v7", k, 0, 0, 0, 0, 0, 0, 0, 0, 7, 7, 0);
        // R2: mixed signedness
        issue("R2 S32 -1 < U32 max", 1, 0, 1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue("R2 U32 max > S32 -1", 4, 1, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue("R2 S16 vs U16", 1, 2, 3, 0, 0, 0, 0, 0, 0, 32'h8000, 32'h8000, 0);
        // R3: lane selects
        issue("R3 U8 byte3 > S8 byte0", 4, 5, 4, 3, 0, 0, 0, 0, 0, 32'h8000_0000, 32'h0000_0080, 0);
        issue("R3 S16 half1 eq", 2, 2, 2, 1, 0, 0, 0, 0, 0, 32'hABCD_0000, 32'h1234_ABCD, 0);
        issue("R3 U32 ignores part", 2, 1, 1, 3, 2, 0, 0, 0, 0, 32'h0102_0304, 32'h0102_0304, 0);
        // R4: immediate
        issue("R4 imm signed -2", 4, 0, 0, 0, 0, 1, 16'hFFFE, 0, 0, 0, 32'hFFFF_FFFF, 0);
        issue("R4 imm unsigned", 1, 0, 1, 0, 3, 1, 16'hFFFE, 0, 0, 0, 0, 0);
        issue("R4 imm ignores b_part", 2, 0, 0, 0, 1, 1, 16'h0004, 0, 0, 4, 32'h0004_0000, 0);
        // R5, R6, R7, R8 with C patterns
        for (int op = 0; op < 8; op++) begin
            issue("R6 R7 R8 R5 post ops hit", 7, 0, 0, 0, 0, 0, 0, op, 0, 0, 0, 32'hA5A5_A5A5);
            issue("R6 R7 R8 R5 post ops miss", 0, 0, 0, 0, 0, 0, 0, op, 0, 0, 0, 32'h5A5A_5A5A);
        end
        issue("R8 min with zero C", 7, 0, 0, 0, 0, 0, 0, 6, 0, 0, 0, 0);
        issue("R8 max with zero C", 7, 0, 0, 0, 0, 0, 0, 7, 0, 0, 0, 0);
        // R7 wrap, R9 flags
        issue("R7 add wraps", 7, 0, 0, 0, 0, 0, 0, 5, 1, 0, 0, 32'hFFFF_FFFF);
        issue("R9 no update", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        issue("R9 sign set", 0, 0, 0, 0, 0, 0, 0, 2, 1, 0, 0, 32'h8000_1234);
        idle(3);
        issue("R10 after gap", 2, 0, 0, 0, 0, 0, 0, 0, 1, 9, 9, 0);
        idle(2);
        // random mix
        for (int n = 0; n < 600; n++) begin
            issue("R1 R2 R3 R4 random", $urandom_range(7), $urandom_range(7), $urandom_range(7),
                  $urandom_range(3), $urandom_range(3), 1'($urandom_range(1)),
                  16'($urandom), $urandom_range(7), 1'($urandom_range(1)),
                  ($urandom_range(1) ? $urandom : 32'($urandom_range(3))),
                  ($urandom_range(1) ? $urandom : 32'($urandom_range(3))),
                  ($urandom_range(1) ? $urandom : 32'($urandom_range(2))));
            if ((n % 37) == 0) idle(1);
        end
        idle(3);
        check(sb_q.size() == 0, "R10 all results seen", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule